// File: doc/BRIEF.md
# Four-Phase Two-Way Sequencer

This block is a control-only handshake element. A parent process starts it through a passive return-to-zero channel (`par_req` in, `par_ack` out). In response it runs two complete four-phase handshakes on its two active child channels, strictly one after the other. The first child channel (`c1_req`/`c1_ack`) finishes before the second child channel (`c2_req`/`c2_ack`) begins. Only when the second child has fully returned to zero does the block acknowledge the parent.

All request and acknowledge levels are synchronous to `clk`, and every output comes straight from a register. The block sits between a controller that must run two operations in order and the two units that carry out those operations. Because the two child activations never overlap, both children can share resources that must not be used at the same time.

Top module: `handshake_sequencer2`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `par_ack`, `c1_req` and `c2_req` are all low.
- R2: When `par_req` is sampled high in the idle state, `c1_req` goes high one cycle later.
- R3: `c1_req` stays high until `c1_ack` is sampled high, and then falls one cycle later.
- R4: `c2_req` rises one cycle after `c1_ack` is sampled low following the fall of `c1_req`, and never earlier.
- R5: `c2_req` stays high until `c2_ack` is sampled high, and then falls one cycle later.
- R6: `par_ack` rises one cycle after `c2_ack` is sampled low following the fall of `c2_req`. It never rises before both child handshakes have completed.
- R7: `par_ack` stays high until `par_req` is sampled low and falls one cycle later. The block is idle again one cycle after that, and a request sampled from then on starts a new sequence.
- R8: `c1_req` and `c2_req` are never high at the same time.
- R9: Across every parent handshake, the output edges occur in this fixed order: `c1_req` rise, `c1_req` fall, `c2_req` rise, `c2_req` fall, `par_ack` rise, `par_ack` fall.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| par_req | input | 1 | Parent activation request |
| par_ack | output | 1 | Parent acknowledge |
| c1_req | output | 1 | First child request |
| c1_ack | input | 1 | First child acknowledge |
| c2_req | output | 1 | Second child request |
| c2_ack | input | 1 | Second child acknowledge |

## Verification
Each output edge is due exactly one clock cycle after the input edge that enables it is sampled. For example, `c2_req` rises one cycle after `c1_ack` is seen low. The bench samples inputs and outputs shortly after each falling clock edge, counts the samples, and stamps each enabling input edge with its sample number. Every output edge is then popped from a scoreboard queue of expected events, which checks its type, and its sample number is compared against the stamp of its cause plus one. The child responders wait a different number of cycles in each test phase: none at all, a random number, and long waits.

// File: rtl/hs_seq_pkg.sv
package hs_seq_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_C1_RISE,
        S_C1_FALL,
        S_C2_RISE,
        S_C2_FALL,
        S_PAR_ACK,
        S_PAR_RTZ
    } seq_state_e;

    typedef struct packed {
        logic par_ack;
        logic c1_req;
        logic c2_req;
    } seq_out_s;

    localparam seq_out_s OUT_IDLE = '{par_ack: 1'b0, c1_req: 1'b0, c2_req: 1'b0};

    // Output levels that belong to each state.
    function automatic seq_out_s levels_of(input seq_state_e s);
        seq_out_s o;
        o = OUT_IDLE;
        case (s)
            S_C1_RISE: o.c1_req  = 1'b1;
            S_C2_RISE: o.c2_req  = 1'b1;
            S_PAR_ACK: o.par_ack = 1'b1;
            default:   o = OUT_IDLE;
        endcase
        return o;
    endfunction

    // Next state from the present state and the sampled handshake inputs.
    function automatic seq_state_e step(input seq_state_e s,
                                        input logic par_req,
                                        input logic c1_ack,
                                        input logic c2_ack);
        seq_state_e n;
        n = s;
        case (s)
            S_IDLE:    if (par_req)  n = S_C1_RISE;
            S_C1_RISE: if (c1_ack)   n = S_C1_FALL;
            S_C1_FALL: if (!c1_ack)  n = S_C2_RISE;
            S_C2_RISE: if (c2_ack)   n = S_C2_FALL;
            S_C2_FALL: if (!c2_ack)  n = S_PAR_ACK;
            S_PAR_ACK: if (!par_req) n = S_PAR_RTZ;
            S_PAR_RTZ: n = S_IDLE;
            default:   n = S_IDLE;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/hs_seq_fsm.sv
module hs_seq_fsm
    import hs_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       par_req,
    input  logic       c1_ack,
    input  logic       c2_ack,
    output seq_state_e state_next
);

    seq_state_e state_q;

    always_comb begin
        state_next = step(state_q, par_req, c1_ack, c2_ack);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_next;
        end
    end

endmodule

// File: rtl/hs_seq_outreg.sv
module hs_seq_outreg
    import hs_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  seq_state_e state_next,
    output seq_out_s   levels_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            levels_q <= OUT_IDLE;
        end else begin
            levels_q <= levels_of(state_next);
        end
    end

endmodule

// File: rtl/handshake_sequencer2.sv
module handshake_sequencer2
    import hs_seq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic par_req,
    output logic par_ack,
    output logic c1_req,
    input  logic c1_ack,
    output logic c2_req,
    input  logic c2_ack
);

    seq_state_e state_next;
    seq_out_s   levels_q;

    hs_seq_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .par_req    (par_req),
        .c1_ack     (c1_ack),
        .c2_ack     (c2_ack),
        .state_next (state_next)
    );

    hs_seq_outreg u_outreg (
        .clk        (clk),
        .rst        (rst),
        .state_next (state_next),
        .levels_q   (levels_q)
    );

    assign par_ack = levels_q.par_ack;
    assign c1_req  = levels_q.c1_req;
    assign c2_req  = levels_q.c2_req;

endmodule

// File: rtl/hs_seq_checker.sv
module hs_seq_checker (
    input logic clk,
    input logic rst,
    input logic par_req,
    input logic par_ack,
    input logic c1_req,
    input logic c1_ack,
    input logic c2_req,
    input logic c2_ack
);

    a_r8_no_overlap: assert property (@(posedge clk) disable iff (rst)
        !(c1_req && c2_req));

    a_r3_c1_ack_needs_req: assert property (@(posedge clk) disable iff (rst)
        $rose(c1_ack) |-> c1_req);

    a_r5_c2_ack_needs_req: assert property (@(posedge clk) disable iff (rst)
        $rose(c2_ack) |-> c2_req);

    a_r2_c1_start: assert property (@(posedge clk) disable iff (rst)
        $rose(c1_req) |-> $past(par_req));

    a_r3_c1_hold: assert property (@(posedge clk) disable iff (rst)
        (c1_req && !c1_ack) |=> c1_req);

    a_r4_c2_after_c1: assert property (@(posedge clk) disable iff (rst)
        $rose(c2_req) |-> (!c1_req && !$past(c1_ack)));

    a_r5_c2_hold: assert property (@(posedge clk) disable iff (rst)
        (c2_req && !c2_ack) |=> c2_req);

    a_r6_par_ack_last: assert property (@(posedge clk) disable iff (rst)
        $rose(par_ack) |-> (!$past(c2_ack) && !c1_req && !c2_req));

    a_r7_par_ack_rtz: assert property (@(posedge clk) disable iff (rst)
        $fell(par_ack) |-> !$past(par_req));

endmodule

bind handshake_sequencer2 hs_seq_checker u_hs_seq_checker (
    .clk     (clk),
    .rst     (rst),
    .par_req (par_req),
    .par_ack (par_ack),
    .c1_req  (c1_req),
    .c1_ack  (c1_ack),
    .c2_req  (c2_req),
    .c2_ack  (c2_ack)
);

// File: tb/test_handshake_sequencer2.sv
module test_handshake_sequencer2;

    typedef enum int {EV_C1_UP, EV_C1_DN, EV_C2_UP, EV_C2_DN, EV_P_UP, EV_P_DN} ev_e;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic par_req = 1'b0;
    logic c1_ack = 1'b0;
    logic c2_ack = 1'b0;
    logic par_ack, c1_req, c2_req;

    int checks = 0;
    int failures = 0;
    int min_dly = 0;
    int max_dly = 0;
    bit done = 1'b0;
    bit mon_on = 1'b0;
    ev_e exp_q[$];

    always #2.5 clk = ~clk;

    handshake_sequencer2 i_handshake_sequencer2 (
        .clk     (clk),
        .rst     (rst),
        .par_req (par_req),
        .par_ack (par_ack),
        .c1_req  (c1_req),
        .c1_ack  (c1_ack),
        .c2_req  (c2_req),
        .c2_ack  (c2_ack)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int pick_dly();
        return $urandom_range(max_dly, min_dly);
    endfunction

    // First child responder
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && c1_req && !c1_ack) begin
                repeat (pick_dly()) @(negedge clk);
                c1_ack = 1'b1;
            end else if (!rst && !c1_req && c1_ack) begin
                repeat (pick_dly()) @(negedge clk);
                c1_ack = 1'b0;
            end
        end
    end

    // Second child responder
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && c2_req && !c2_ack) begin
                repeat (pick_dly()) @(negedge clk);
                c2_ack = 1'b1;
            end else if (!rst && !c2_req && c2_ack) begin
                repeat (pick_dly()) @(negedge clk);
                c2_ack = 1'b0;
            end
        end
    end

    // Monitor: samples 1 ns after each falling edge, stamps input edges,
    // pops expected events and checks order (R9) and one-cycle latency.
    initial begin
        int n = 0;
        int st_preq_up = 0, st_preq_dn = 0, st_c1a_up = 0, st_c1a_dn = 0;
        int st_c2a_up = 0, st_c2a_dn = 0;
        logic pp = 0, pc1a = 0, pc2a = 0, ppa = 0, pc1r = 0, pc2r = 0;
        forever begin
            @(negedge clk);
            #1;
            n++;
            if (mon_on) begin
                bit have;
                ev_e got;
                int cause;
                string tag;
                if (par_req && !pp) st_preq_up = n;
                if (!par_req && pp) st_preq_dn = n;
                if (c1_ack && !pc1a) st_c1a_up = n;
                if (!c1_ack && pc1a) st_c1a_dn = n;
                if (c2_ack && !pc2a) st_c2a_up = n;
                if (!c2_ack && pc2a) st_c2a_dn = n;
                // R8: no overlap of child requests
                check(!(c1_req && c2_req), "R8", int'(c1_req) + int'(c2_req), 1);
                have = 1'b1;
                if (c1_req && !pc1r)       begin got = EV_C1_UP; cause = st_preq_up; tag = "R2"; end
                else if (!c1_req && pc1r)  begin got = EV_C1_DN; cause = st_c1a_up;  tag = "R3"; end
                else if (c2_req && !pc2r)  begin got = EV_C2_UP; cause = st_c1a_dn;  tag = "R4"; end
                else if (!c2_req && pc2r)  begin got = EV_C2_DN; cause = st_c2a_up;  tag = "R5"; end
                else if (par_ack && !ppa)  begin got = EV_P_UP;  cause = st_c2a_dn;  tag = "R6"; end
                else if (!par_ack && ppa)  begin got = EV_P_DN;  cause = st_preq_dn; tag = "R7"; end
                else have = 1'b0;
                if (have) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R9", int'(got), -1);
                    end else begin
                        ev_e e;
                        e = exp_q.pop_front();
                        check(got == e, "R9", int'(got), int'(e));
                    end
                    check(n == cause + 1, tag, n - cause, 1);
                end
            end
            pp = par_req; pc1a = c1_ack; pc2a = c2_ack;
            ppa = par_ack; pc1r = c1_req; pc2r = c2_req;
        end
    end

    task automatic run_parent(input int hold, input int gap);
        exp_q.push_back(EV_C1_UP);
        exp_q.push_back(EV_C1_DN);
        exp_q.push_back(EV_C2_UP);
        exp_q.push_back(EV_C2_DN);
        exp_q.push_back(EV_P_UP);
        exp_q.push_back(EV_P_DN);
        par_req = 1'b1;
        do @(negedge clk); while (!par_ack);
        repeat (hold) @(negedge clk);
        par_req = 1'b0;
        do @(negedge clk); while (par_ack);
        // block is idle one cycle after par_ack falls (R7)
        repeat (1 + gap) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!par_ack && !c1_req && !c2_req, "R1",
              int'({par_ack, c1_req, c2_req}), 0);
        rst = 1'b0;
        #1;
        @(negedge clk);
        check(!par_ack && !c1_req && !c2_req, "R1",
              int'({par_ack, c1_req, c2_req}), 0);
        mon_on = 1'b1;
        // Phase A: zero-latency responders, back-to-back parents
        min_dly = 0; max_dly = 0;
        for (int i = 0; i < 4; i++) run_parent(0, 0);
        // Phase B: random responder latencies
        min_dly = 0; max_dly = 5;
        for (int i = 0; i < 20; i++) run_parent($urandom_range(3, 0), $urandom_range(3, 0));
        // Phase C: long responder latencies
        min_dly = 8; max_dly = 20;
        for (int i = 0; i < 4; i++) run_parent(2, 1);
        repeat (5) @(negedge clk);
        // R9: every expected event was produced
        check(exp_q.size() == 0, "R9", exp_q.size(), 0);
        check(!par_ack && !c1_req && !c2_req, "R7",
              int'({par_ack, c1_req, c2_req}), 0);
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

endmodule